// File: doc/BRIEF.md
# Burst-Mode Oversampling Phase Selector

This block recovers data from short upstream bursts at the receiver of a passive optical network. The analog front end samples the serial line with eight equally spaced clock phases and hands the block, once per bit period, a vector of eight phase samples. Sample index 0 is the earliest phase of the bit period. During the alternating-bit preamble that opens every burst, the block records where the bit transitions fall between neighbouring samples. It counts these transitions per position over a fixed window, then picks the tap half a bit period away from the most frequent transition position. After that it emits retimed data from that tap, together with a lock flag.

Acquisition is one-shot. There is no tracking loop. Once a tap is chosen it stays fixed until a re-arm pulse or reset. A re-arm pulse starts a fresh acquisition for the next burst. A free-running byte strobe, one cycle in every eight bit periods, runs without a break across bursts and gaps. Downstream logic uses it as the byte-rate timing reference.

Top module: `burst_phase_sel`

## Requirements
- R1: A transition at position i (1..7) is recorded when sample i differs from sample i-1 of the same bit. Position 0 is recorded when sample 0 differs from sample 7 of the previous bit. Position 0 is not recorded on the first bit after reset or re-arm.
- R2: Transitions are counted per position over a window of WIN_BITS bits (default 8), starting at the first bit after reset or re-arm. If the window holds at least MIN_EDGES transitions (default 4), lock rises after the window's last bit is clocked in, and not earlier.
- R3: The chosen tap is (p + 4) mod 8, where p is the position with the highest count. When counts tie, the lowest position wins.
- R4: A window with fewer than MIN_EDGES transitions leaves lock low. It clears all counts, and a new window begins on the next bit.
- R5: With a clean alternating preamble starting right after re-arm, lock is high within 13 bit periods.
- R6: While locked, the chosen tap cannot change until re-arm or reset, whatever transitions the input later shows.
- R7: dout carries sample[tap] of bit n after the clock edge that follows the one at which bit n was presented. dvalid is high exactly when that sample was taken while locked.
- R8: A re-arm pulse drops lock and dvalid at the next edge and restarts acquisition.
- R9: byte_tick is high for one cycle in every eight, starting seven cycles after reset. It is unaffected by re-arm, lock or data.
- R10: During reset lock, dvalid, dout and byte_tick are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-period clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rearm | input | 1 | Synchronous pulse that clears lock and restarts acquisition |
| samp | input | NTAPS | Phase samples of the current bit, index 0 earliest |
| lock | output | 1 | High once a tap has been chosen |
| dout | output | 1 | Retimed data bit |
| dvalid | output | 1 | dout holds a sample taken while locked |
| byte_tick | output | 1 | One-cycle strobe every BYTE_BITS cycles |

## Verification
The hardest situations to reach are a window that fails and is followed by a good one, and a histogram tie. A failure needs a burst that toggles too rarely. A tie needs two transition positions that are exactly equally populated. The bench builds every sample vector from a chosen transition position and the current and previous line values. It drives a preamble that changes only every other bit, which gives three transitions in eight bits, and then a clean preamble, and checks that lock rises only at the end of the second window. For the tie it alternates the transition between two positions, then reads the chosen tap back through dout using data whose transition sits where the two candidate taps give different bits.

// File: rtl/burst_psel_pkg.sv
package burst_psel_pkg;

    typedef enum logic {
        ST_ACQ  = 1'b0,
        ST_LOCK = 1'b1
    } psel_mode_e;

    // Index arithmetic on a ring of m taps.
    function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned m);
        return (a + b) % m;
    endfunction

endpackage

// File: rtl/psel_edge_det.sv
module psel_edge_det #(
    parameter int NTAPS = 8
) (
    input  logic [NTAPS-1:0] samp,
    input  logic             prev_last,
    input  logic             prev_ok,
    output logic [NTAPS-1:0] edges
);
    // Position 0 straddles the bit boundary.
    assign edges[0] = prev_ok & (prev_last ^ samp[0]);

    generate
        for (genvar i = 1; i < NTAPS; i++) begin : g_pos
            assign edges[i] = samp[i] ^ samp[i-1];
        end
    endgenerate
endmodule

// File: rtl/psel_hist.sv
module psel_hist #(
    parameter int NTAPS = 8,
    parameter int CW    = 4,
    parameter int SW    = 7
) (
    input  logic [NTAPS-1:0][CW-1:0] hist_q,
    input  logic [NTAPS-1:0]         edges,
    output logic [NTAPS-1:0][CW-1:0] hist_inc,
    output logic [SW-1:0]            total
);
    generate
        for (genvar i = 0; i < NTAPS; i++) begin : g_bin
            assign hist_inc[i] = hist_q[i] + CW'(edges[i]);
        end
    endgenerate

    always_comb begin
        total = '0;
        for (int i = 0; i < NTAPS; i++) begin
            total = total + SW'(hist_inc[i]);
        end
    end
endmodule

// File: rtl/psel_peak.sv
module psel_peak #(
    parameter int NTAPS = 8,
    parameter int CW    = 4,
    parameter int TW    = 3
) (
    input  logic [NTAPS-1:0][CW-1:0] hist,
    output logic [TW-1:0]            peak
);
    logic [CW-1:0] best;

    // Strict comparison keeps the lowest position on a tie.
    always_comb begin
        best = '0;
        peak = '0;
        for (int i = 0; i < NTAPS; i++) begin
            if (hist[i] > best) begin
                best = hist[i];
                peak = TW'(i);
            end
        end
    end
endmodule

// File: rtl/burst_phase_sel.sv
module burst_phase_sel
    import burst_psel_pkg::*;
#(
    parameter int NTAPS     = 8,
    parameter int WIN_BITS  = 8,
    parameter int MIN_EDGES = 4,
    parameter int BYTE_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rearm,
    input  logic [NTAPS-1:0] samp,
    output logic             lock,
    output logic             dout,
    output logic             dvalid,
    output logic             byte_tick
);
    localparam int TW = $clog2(NTAPS);
    localparam int CW = $clog2(WIN_BITS + 1);
    localparam int SW = $clog2(NTAPS * WIN_BITS + 1);
    localparam int BW = $clog2(BYTE_BITS);
    localparam int unsigned HALF = NTAPS / 2;
    localparam logic [CW-1:0] WIN_LAST  = CW'(WIN_BITS - 1);
    localparam logic [SW-1:0] MIN_V     = SW'(MIN_EDGES);
    localparam logic [BW-1:0] TICK_LAST = BW'(BYTE_BITS - 1);

    typedef struct packed {
        psel_mode_e              mode;
        logic [CW-1:0]           win;
        logic [NTAPS-1:0][CW-1:0] hist;
        logic [TW-1:0]           sel;
        logic                    prev_last;
        logic                    prev_ok;
        logic                    s1;
        logic                    s1_v;
        logic                    dout;
        logic                    dvalid;
        logic [BW-1:0]           tick;
    } psel_st_t;

    psel_st_t q, d;

    logic [NTAPS-1:0]          edges;
    logic [NTAPS-1:0][CW-1:0]  hist_inc;
    logic [SW-1:0]             total;
    logic [TW-1:0]             peak;
    logic [TW-1:0]             sel_pick;
    logic [TW-1:0]             sel_w;

    psel_edge_det #(.NTAPS(NTAPS)) u_edge (
        .samp      (samp),
        .prev_last (q.prev_last),
        .prev_ok   (q.prev_ok),
        .edges     (edges)
    );

    psel_hist #(.NTAPS(NTAPS), .CW(CW), .SW(SW)) u_hist (
        .hist_q   (q.hist),
        .edges    (edges),
        .hist_inc (hist_inc),
        .total    (total)
    );

    psel_peak #(.NTAPS(NTAPS), .CW(CW), .TW(TW)) u_peak (
        .hist (hist_inc),
        .peak (peak)
    );

    // Eye centre: half a bit period away from the dominant transition.
    assign sel_pick = TW'(ring_add(32'(peak), HALF, NTAPS));

    always_comb begin
        d = q;

        d.tick      = (q.tick == TICK_LAST) ? '0 : q.tick + 1'b1;
        d.prev_last = samp[NTAPS-1];
        d.prev_ok   = 1'b1;

        // Two-stage retiming: sample, then present.
        d.s1     = samp[q.sel];
        d.s1_v   = (q.mode == ST_LOCK);
        d.dout   = q.s1;
        d.dvalid = q.s1_v;

        if (q.mode == ST_ACQ) begin
            if (q.win == WIN_LAST) begin
                d.win  = '0;
                d.hist = '0;
                if (total >= MIN_V) begin
                    d.mode = ST_LOCK;
                    d.sel  = sel_pick;
                end
            end else begin
                d.win  = q.win + 1'b1;
                d.hist = hist_inc;
            end
        end

        if (rearm) begin
            d.mode    = ST_ACQ;
            d.win     = '0;
            d.hist    = '0;
            d.sel     = '0;
            d.prev_ok = 1'b0;
            d.s1      = 1'b0;
            d.s1_v    = 1'b0;
            d.dout    = 1'b0;
            d.dvalid  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign lock      = (q.mode == ST_LOCK);
    assign dout      = q.dout;
    assign dvalid    = q.dvalid;
    assign byte_tick = (q.tick == TICK_LAST);
    assign sel_w     = q.sel;

endmodule

// File: rtl/burst_phase_sel_chk.sv
module burst_phase_sel_chk #(
    parameter int WIN_BITS  = 8,
    parameter int BYTE_BITS = 8,
    parameter int TW        = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rearm,
    input logic          lock,
    input logic          dvalid,
    input logic          byte_tick,
    input logic [TW-1:0] sel
);
    logic [15:0] acq_cnt;
    logic [15:0] gap_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acq_cnt <= '0;
            gap_cnt <= '0;
        end else begin
            if (rearm)
                acq_cnt <= '0;
            else if (acq_cnt != 16'hFFFF)
                acq_cnt <= acq_cnt + 16'd1;
            gap_cnt <= byte_tick ? 16'd0 : gap_cnt + 16'd1;
        end
    end

    // R6
    sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !rearm) |=> (lock && $stable(sel)));

    // R8
    rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> (!lock && !dvalid));

    // R7
    valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid |-> $past(lock));

    // R2
    lock_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> (acq_cnt >= 16'(WIN_BITS)));

    // R9
    tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_tick |-> (gap_cnt == 16'(BYTE_BITS - 1)));

endmodule

bind burst_phase_sel burst_phase_sel_chk #(
    .WIN_BITS  (WIN_BITS),
    .BYTE_BITS (BYTE_BITS),
    .TW        (TW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rearm     (rearm),
    .lock      (lock),
    .dvalid    (dvalid),
    .byte_tick (byte_tick),
    .sel       (sel_w)
);

// File: tb/burst_phase_sel_tb.sv
module burst_phase_sel_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rearm = 1'b0;
    logic [7:0] samp = 8'hFF;
    logic       lock, dout, dvalid, byte_tick;

    int   checks = 0;
    int   errs   = 0;
    bit   done   = 1'b0;
    logic line   = 1'b1;
    logic [7:0]  vh0 = 8'hFF, vh1 = 8'hFF;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    burst_phase_sel u_dut (
        .clk(clk), .rst_n(rst_n), .rearm(rearm), .samp(samp),
        .lock(lock), .dout(dout), .dvalid(dvalid), .byte_tick(byte_tick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mkvec(input int p, input logic cur, input logic prv);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = (i >= p) ? cur : prv;
        return v;
    endfunction

    task automatic step(input logic [7:0] v);
        samp = v;
        vh1  = vh0;
        vh0  = v;
        @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input int p, input logic b);
        logic [7:0] v;
        v = mkvec(p, b, line);
        line = b;
        step(v);
    endtask

    task automatic do_rearm();
        rearm = 1'b1;
        line  = 1'b1;
        step(8'hFF);
        rearm = 1'b0;
    endtask

    function automatic logic next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // Random data with transitions at position p; dout checked against tap s.
    task automatic data_run(input int p, input int s, input int n, input string req);
        for (int k = 0; k < n; k++) begin
            send_bit(p, next_rand());
            chk(dvalid == 1'b1, {req, " dvalid"}, dvalid, 1);
            chk(dout == vh1[s], {req, " dout"}, dout, vh1[s]);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin : main
        int ticks;
        int last_t;
        #1;
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk(lock == 0,      "R10 lock",      lock, 0);
        chk(dvalid == 0,    "R10 dvalid",    dvalid, 0);
        chk(dout == 0,      "R10 dout",      dout, 0);
        chk(byte_tick == 0, "R10 byte_tick", byte_tick, 0);
        rst_n = 1'b1;

        // R9 byte strobe period, with a re-arm in the middle
        ticks = 0;
        last_t = -1;
        for (int c = 0; c < 40; c++) begin
            rearm = (c == 13);
            step(8'hFF);
            if (byte_tick) begin
                ticks++;
                if (last_t < 0) chk(c == 6, "R9 first tick", c, 6);
                else chk(c - last_t == 8, "R9 gap", c - last_t, 8);
                last_t = c;
            end
        end
        rearm = 1'b0;
        chk(ticks == 5, "R9 tick count", ticks, 5);

        // R1 R2 R3 R5 R7 sweep over every transition position
        for (int p = 0; p < 8; p++) begin
            do_rearm();
            for (int n = 0; n < 8; n++) begin
                send_bit(p, ~line);
                if (n == 6) chk(lock == 0, "R2 early lock", lock, 0);
            end
            chk(lock == 1, "R5 R1 lock after preamble", lock, 1);
            send_bit(p, next_rand());
            chk(dvalid == 0, "R7 dvalid latency", dvalid, 0);
            data_run(p, (p + 4) % 8, 6, "R3 R7 sweep");
        end

        // R3 dominant position: 6 at 3, 2 at 4 -> tap 7
        do_rearm();
        for (int n = 0; n < 8; n++) send_bit((n % 3 == 2) ? 4 : 3, ~line);
        chk(lock == 1, "R3 jitter lock", lock, 1);
        send_bit(3, 1'b0);
        data_run(3, 7, 6, "R3 jitter tap");

        // R3 tie between 2 and 6 -> lowest (2) -> tap 6
        do_rearm();
        for (int n = 0; n < 8; n++) send_bit((n % 2 == 0) ? 2 : 6, ~line);
        chk(lock == 1, "R3 tie lock", lock, 1);
        send_bit(4, 1'b0);
        data_run(4, 6, 6, "R3 tie tap");

        // R4 idle window, then a sparse window, then a clean one
        do_rearm();
        for (int n = 0; n < 8; n++) send_bit(2, 1'b1);
        chk(lock == 0, "R4 idle no lock", lock, 0);
        for (int n = 0; n < 8; n++) send_bit(2, (n % 4) < 2 ? 1'b1 : 1'b0);
        chk(lock == 0, "R4 sparse no lock", lock, 0);
        for (int n = 0; n < 8; n++) begin
            send_bit(2, ~line);
            if (n == 6) chk(lock == 0, "R4 retry window early", lock, 0);
        end
        chk(lock == 1, "R4 retry lock", lock, 1);
        send_bit(4, 1'b0);
        data_run(4, 6, 4, "R4 retry tap");

        // R6 frozen tap under shifted data
        do_rearm();
        for (int n = 0; n < 8; n++) send_bit(1, ~line);
        send_bit(1, 1'b0);
        data_run(1, 5, 3, "R6 before shift");
        for (int n = 0; n < 3; n++) send_bit(6, ~line);
        data_run(6, 5, 16, "R6 frozen tap");
        chk(lock == 1, "R6 lock held", lock, 1);

        // R8 re-arm
        do_rearm();
        chk(lock == 0,   "R8 lock cleared",   lock, 0);
        chk(dvalid == 0, "R8 dvalid cleared", dvalid, 0);
        send_bit(1, 1'b0);
        chk(dvalid == 0, "R8 dvalid stays low", dvalid, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule